// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block selects which of fifteen interrupt requests an 8-bit processor core services next. Each source can be placed at one of two levels by a per-source level bit. Within a level, a fixed polling order that interleaves the sources decides the winner. This order is not the same as the order of the vector table. The block evaluates the request inputs once per machine cycle. When it accepts a request, it emits a one-clock take strobe together with the source index and the 16-bit entry address of that source's service routine.

The controller tracks which levels are in service, one flag per level, so that it can apply the nesting rules. A routine at the low level can be interrupted only by a high-level request. A routine at the high level cannot be interrupted at all. The processor reports the end of a routine with a one-clock return strobe, which releases the innermost active level. Clearing the request flags inside the peripherals and saving the processor's stack are handled elsewhere.

Top module: `vic_core`

## Requirements
- R1: A taken source with index i (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial 0, 5 CAN, 6..9 capture 0..3, 10 converter done, 11..13 compare 0..2, 14 timer 2 overflow) drives `src_idx` = i and `vector` = 0x0003 + 8*i.
- R2: Among eligible requests of one level, the winner is the one earliest in the index order 0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14.
- R3: When no level is in service and eligible requests exist at both levels, a high-level request (`lvl_sel` bit = 1) is taken.
- R4: While only the low level is in service, low-level requests are not taken and high-level requests are taken.
- R5: While the high level is in service, no request of either level is taken.
- R6: A request is eligible only when its `req` bit, its `src_en` bit and `glb_en` are all 1.
- R7: `take` is high for exactly one clock per accepted request, and `vector` and `src_idx` keep the last accepted values until the next take.
- R8: Arbitration happens once every CYC_DIV clocks, so successive takes are at least CYC_DIV clocks apart, and exactly CYC_DIV apart when a request is ready at the next evaluation.
- R9: A `reti` pulse clears the high in-service flag if it is set, and otherwise clears the low one.
- R10: After reset, `take`, `vector` and `src_idx` are 0 and neither level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 15 | Request lines, one per source index |
| src_en | input | 15 | Per-source enable bits |
| glb_en | input | 1 | Global enable |
| lvl_sel | input | 15 | Level per source, 1 = high |
| reti | input | 1 | Return-from-routine strobe |
| take | output | 1 | One-clock strobe when a request is accepted |
| vector | output | 16 | Entry address of the accepted source |
| src_idx | output | 4 | Index of the accepted source |

## Verification
The assertions assume that `reti` arrives only for a routine that was actually taken. They also assume that a source index above 14 is never presented. The bench meets both assumptions: every return pulse it issues follows a take, and it builds its request patterns from indices 0 to 14 only. Every pair of simultaneous same-level requests is tried at both levels. Before each step the bench drops all requests and returns from the routine it entered, so no routine is left in service going into the next step.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // Map a polling rank to a source index: sources are polled in groups,
    // taking one member from each of NPER banks of NGRP sources in turn.
    function automatic int unsigned rank_to_src(int unsigned rank,
                                                int unsigned ngrp,
                                                int unsigned nper);
        return (rank % nper) * ngrp + rank / nper;
    endfunction

    typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
endpackage

// File: rtl/vic_tick.sv
module vic_tick #(
    parameter int unsigned CYC_DIV = 4,
    localparam int unsigned CNT_W = (CYC_DIV > 2) ? $clog2(CYC_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CNT_W'(CYC_DIV - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/vic_pick.sv
module vic_pick
    import vic_pkg::*;
#(
    parameter int unsigned NGRP = 5,
    parameter int unsigned NPER = 3,
    localparam int unsigned NSRC = NGRP * NPER,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [NSRC-1:0]  by_rank;
    logic [IDX_W-1:0] rank_src [NSRC];

    for (genvar k = 0; k < NSRC; k++) begin : g_rank
        localparam int unsigned SRC_K = rank_to_src(k, NGRP, NPER);
        assign by_rank[k]  = mask[SRC_K];
        assign rank_src[k] = IDX_W'(SRC_K);
    end

    // Scan from the last rank to the first so the earliest rank wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (by_rank[k]) begin
                found = 1'b1;
                idx   = rank_src[k];
            end
        end
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int unsigned NGRP     = 5,
    parameter int unsigned NPER     = 3,
    parameter int unsigned CYC_DIV  = 4,
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8,
    localparam int unsigned NSRC  = NGRP * NPER,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  src_en,
    input  logic             glb_en,
    input  logic [NSRC-1:0]  lvl_sel,
    input  logic             reti,
    output logic             take,
    output logic [VEC_W-1:0] vector,
    output logic [IDX_W-1:0] src_idx
);
    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic [IDX_W-1:0] idx;
        logic             svc_hi;
        logic             svc_lo;
    } state_t;

    state_t st_d, st_q;

    logic             tick;
    logic [NSRC-1:0]  elig;
    logic [NSRC-1:0]  lvl_mask [2];
    logic             fnd  [2];
    logic [IDX_W-1:0] pidx [2];

    vic_tick #(.CYC_DIV(CYC_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign elig        = req & src_en & {NSRC{glb_en}};
    assign lvl_mask[0] = elig & ~lvl_sel;
    assign lvl_mask[1] = elig & lvl_sel;

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        vic_pick #(.NGRP(NGRP), .NPER(NPER)) u_pick (
            .mask (lvl_mask[g]),
            .found(fnd[g]),
            .idx  (pidx[g])
        );
    end

    logic             grant;
    lvl_e             glvl;
    logic [IDX_W-1:0] gidx;

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        grant     = 1'b0;
        glvl      = LVL_LO;
        gidx      = '0;

        // Decision uses the in-service state held before this edge.
        if (tick && !st_q.svc_hi) begin
            if (fnd[1]) begin
                grant = 1'b1;
                glvl  = LVL_HI;
                gidx  = pidx[1];
            end else if (fnd[0] && !st_q.svc_lo) begin
                grant = 1'b1;
                glvl  = LVL_LO;
                gidx  = pidx[0];
            end
        end

        // Return releases the innermost level.
        if (reti) begin
            if (st_q.svc_hi) st_d.svc_hi = 1'b0;
            else             st_d.svc_lo = 1'b0;
        end

        if (grant) begin
            st_d.take = 1'b1;
            st_d.idx  = gidx;
            st_d.vec  = VEC_W'(VEC_BASE) + VEC_W'(gidx) * VEC_W'(VEC_STEP);
            if (glvl == LVL_HI) st_d.svc_hi = 1'b1;
            else                st_d.svc_lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take    = st_q.take;
    assign vector  = st_q.vec;
    assign src_idx = st_q.idx;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int unsigned NGRP     = 5,
    parameter int unsigned NPER     = 3,
    parameter int unsigned CYC_DIV  = 4,
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8,
    localparam int unsigned NSRC  = NGRP * NPER,
    localparam int unsigned IDX_W = $clog2(NSRC),
    localparam int unsigned GAP_W = $clog2(CYC_DIV + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  req,
    input logic [NSRC-1:0]  src_en,
    input logic             glb_en,
    input logic [NSRC-1:0]  lvl_sel,
    input logic             reti,
    input logic             take,
    input logic [VEC_W-1:0] vector,
    input logic [IDX_W-1:0] src_idx
);
    logic [NSRC-1:0]  req_p, en_p, lvl_p;
    logic             glb_p;
    logic             busy_hi, busy_lo, hi_n, lo_n;
    logic [GAP_W-1:0] gap;

    always_comb begin
        hi_n = busy_hi | (take & lvl_p[src_idx]);
        lo_n = busy_lo | (take & ~lvl_p[src_idx]);
        if (reti) begin
            if (hi_n) hi_n = 1'b0;
            else      lo_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_p   <= '0;
            en_p    <= '0;
            lvl_p   <= '0;
            glb_p   <= 1'b0;
            busy_hi <= 1'b0;
            busy_lo <= 1'b0;
            gap     <= GAP_W'(CYC_DIV);
        end else begin
            req_p   <= req;
            en_p    <= src_en;
            lvl_p   <= lvl_sel;
            glb_p   <= glb_en;
            busy_hi <= hi_n;
            busy_lo <= lo_n;
            if (take)                      gap <= '0;
            else if (gap != GAP_W'(CYC_DIV)) gap <= gap + 1'b1;
        end
    end

    p_vec_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> vector == VEC_W'(VEC_BASE) + VEC_W'(src_idx) * VEC_W'(VEC_STEP));

    p_hi_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && glb_p && (|(req_p & en_p & lvl_p)) |-> lvl_p[src_idx]);

    p_lo_only_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && $past(busy_lo) |-> lvl_p[src_idx]);

    p_hi_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(busy_hi));

    p_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (req_p[src_idx] && en_p[src_idx] && glb_p));

    p_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> $stable(src_idx) && $stable(vector));

    p_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> gap >= GAP_W'(CYC_DIV - 1));
endmodule

bind vic_core vic_chk #(
    .NGRP(NGRP), .NPER(NPER), .CYC_DIV(CYC_DIV),
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .src_en(src_en), .glb_en(glb_en),
    .lvl_sel(lvl_sel), .reti(reti), .take(take), .vector(vector),
    .src_idx(src_idx)
);

// File: tb/sim_vic_core.sv
module sim_vic_core;
    localparam int CYC = 4;
    localparam int N   = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0, src_en = '0, lvl_sel = '0;
    logic          glb_en = 1'b0, reti = 1'b0;
    logic          take;
    logic [15:0]   vector;
    logic [3:0]    src_idx;

    vic_core #(.CYC_DIV(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .src_en(src_en), .glb_en(glb_en),
        .lvl_sel(lvl_sel), .reti(reti), .take(take), .vector(vector),
        .src_idx(src_idx)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, ntake = 0, cyc = 0;
    int t_last = 0, t_prev = 0;
    bit last_take = 0, done = 0;
    int exp_q[$];
    string tag_q[$];

    // Polling order from R2, written out independently.
    int order[N] = '{0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14};

    function automatic int rank_of(int s);
        for (int k = 0; k < N; k++) if (order[k] == s) return k;
        return N;
    endfunction

    function automatic void chk(bit ok, string r, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, expv);
        end
    endfunction

    always @(posedge clk) cyc++;

    // Monitor: pop the scoreboard on each take.
    always @(negedge clk) begin
        if (rst_n) begin
            if (last_take) chk(!take, "R7", take, 0);
            if (take) begin
                ntake++;
                t_prev = t_last;
                t_last = cyc;
                if (exp_q.size() == 0) begin
                    chk(0, "unexpected take", src_idx, -1);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(src_idx == e, t, src_idx, e);
                    chk(vector == 16'(3 + 8 * e), "R1", vector, 3 + 8 * e);
                end
            end
            last_take = take;
        end
    end

    task automatic expect_take(int idx, string r);
        int n0 = ntake;
        exp_q.push_back(idx);
        tag_q.push_back(r);
        for (int w = 0; w < 8 * CYC && ntake == n0; w++) begin
            @(negedge clk);
            #1;
        end
        if (ntake == n0) chk(0, {r, " no take"}, 0, 1);
    endtask

    task automatic expect_none(string r);
        int n0 = ntake;
        repeat (3 * CYC) @(negedge clk);
        #1;
        chk(ntake == n0, r, ntake - n0, 0);
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(take == 0, "R10", take, 0);
        chk(vector == 0, "R10", vector, 0);
        chk(src_idx == 0, "R10", src_idx, 0);
        rst_n = 1'b1;
        src_en = '1;
        glb_en = 1'b1;

        // R1: each source alone, with R7 hold afterwards
        for (int i = 0; i < N; i++) begin
            req = N'(1) << i;
            expect_take(i, "R1");
            req = '0;
            pulse_reti();
            repeat (2) @(negedge clk);
            chk(src_idx == 4'(i), "R7 hold", src_idx, i);
        end

        // R2: every same-level pair, both levels
        for (int lv = 0; lv < 2; lv++) begin
            lvl_sel = lv ? '1 : '0;
            for (int i = 0; i < N; i++) begin
                for (int j = i + 1; j < N; j++) begin
                    req = (N'(1) << i) | (N'(1) << j);
                    expect_take(rank_of(i) < rank_of(j) ? i : j, "R2");
                    req = '0;
                    pulse_reti();
                end
            end
        end
        lvl_sel = '0;

        // R3: high beats low even against the first-polled low source
        req = N'(1) | (N'(1) << 14);
        lvl_sel = N'(1) << 14;
        expect_take(14, "R3");
        req = '0;
        pulse_reti();
        lvl_sel = '0;

        // R6: per-source and global enables
        req = N'(1) << 3;
        src_en = ~(N'(1) << 3);
        expect_none("R6 src_en");
        src_en = '1;
        glb_en = 1'b0;
        expect_none("R6 glb_en");
        glb_en = 1'b1;
        expect_take(3, "R6");
        req = '0;
        pulse_reti();

        // R4 / R9: low in service
        req = N'(1);
        expect_take(0, "R4");
        req = N'(1) << 5;
        expect_none("R4 low blocked");
        lvl_sel = N'(1) << 5;
        expect_take(5, "R4 preempt");
        req = '0;
        lvl_sel = '0;
        pulse_reti();                     // clears high only
        req = N'(1) << 1;
        expect_none("R9 low still busy");
        pulse_reti();                     // clears low
        expect_take(1, "R9");
        req = '0;
        pulse_reti();

        // R5: high in service
        lvl_sel = N'(1) << 2;
        req = N'(1) << 2;
        expect_take(2, "R5");
        lvl_sel = N'(1) << 7;
        req = N'(1) << 7;
        expect_none("R5 high blocked");
        lvl_sel = '0;
        expect_none("R5 low blocked");
        pulse_reti();
        expect_take(7, "R5 after return");
        req = '0;
        pulse_reti();

        // R8: back-to-back takes land exactly one machine cycle apart
        req = N'(1) << 4;
        expect_take(4, "R8");
        lvl_sel = N'(1) << 9;
        req = N'(1) << 9;
        expect_take(9, "R8");
        chk(t_last - t_prev == CYC, "R8", t_last - t_prev, CYC);
        req = '0;
        lvl_sel = '0;
        pulse_reti();
        pulse_reti();
        repeat (4) @(negedge clk);

        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule